// File: doc/BRIEF.md
# Serial DAC Command Front End

This block is the digital front end of a 13-bit voltage-output DAC. A host writes it over a three-wire serial slave port: an active-low chip select, a serial clock and a data line. Each frame is 16 bits long, sent most significant bit first. The first three bits are a command and the last thirteen are a data code. All three serial lines are brought into the system clock domain through two-flop synchronisers, and the block detects edges there. The system clock must run at least four times faster than the serial clock.

Two storage registers sit behind the port. The input register can be written on its own, without changing the converter. The DAC register drives the parallel code to the converter, and it can be written directly or loaded from the input register. A shutdown flag drives both the power-down output and the output high-impedance enable. While the flag is set, both stored codes are kept and the port still accepts frames. Shutdown ends in one of two ways: a recall command, which brings back the previous output, or a command that writes the DAC register. A received word takes effect only when chip select is released, and only if exactly 16 clock edges arrived while chip select was low.

Top module: `serial_dac_frontend`

## Requirements
- R1: After reset, `dac_code` is 0 and `pwr_down` and `out_hiz` are both 0.
- R2: A frame is 16 bits, sampled on rising `sclk` edges while `cs_n` is low and sent MSB first. Bits 15:13 are the command and bits 12:0 are the data. Command 3'b011 writes the data into both the input register and the DAC register, so `dac_code` takes the data value.
- R3: Command 3'b001 writes only the input register and leaves `dac_code` unchanged. Command 3'b010 copies the input register into the DAC register.
- R4: While `cs_n` is high, edges on `sclk` and the value of `din` have no effect on any register or output.
- R5: A complete frame changes no register until `cs_n` rises. The update appears within 10 system clocks of that rise.
- R6: A frame may arrive as two bursts of 8 clocks with an idle gap between them, provided `cs_n` stays low throughout.
- R7: If `cs_n` rises after any number of `sclk` rising edges other than exactly 16 (for example 15 or 17), the frame is discarded and no register changes.
- R8: Command 3'b111 sets the shutdown flag. `pwr_down` and `out_hiz` both go to 1, the data bits are ignored and `dac_code` keeps its value.
- R9: During shutdown the port stays active. Command 3'b001 updates the input register and the block stays in shutdown.
- R10: Command 3'b101 clears the shutdown flag and leaves the DAC register unchanged.
- R11: Commands 3'b010 and 3'b011 write the DAC register and clear the shutdown flag.
- R12: Commands 3'b000, 3'b100 and 3'b110 change neither register nor the shutdown flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| din | input | 1 | Serial data in, MSB first |
| dac_code | output | 13 | Contents of the DAC register |
| pwr_down | output | 1 | High while in shutdown |
| out_hiz | output | 1 | Output high-impedance enable, high while in shutdown |

## Verification
Some properties are checked by assertions on every cycle. The bit counter never goes past its saturation value. A frame is accepted only in the cycle after a chip-select rise. The DAC register holds still in every cycle that follows no accepted frame. The shutdown flag changes only right after an accepted frame. Other behaviour can only be shown by the bench scenarios: the command encoding itself, rejection of frames with a wrong bit count, split bursts, values held through shutdown, and the difference between a recall exit and a new-data exit.

// File: rtl/serial_dac_pkg.sv
package serial_dac_pkg;

    localparam int DAC_BITS = 13;
    localparam int OP_BITS  = 3;

    typedef enum logic [OP_BITS-1:0] {
        OP_IDLE     = 3'b000,
        OP_STAGE    = 3'b001,
        OP_COMMIT   = 3'b010,
        OP_DIRECT   = 3'b011,
        OP_RSVD_A   = 3'b100,
        OP_WAKE     = 3'b101,
        OP_RSVD_B   = 3'b110,
        OP_SLEEP    = 3'b111
    } op_e;

endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] IDLE_LV = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] synced
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.chain[0] = raw_in;
        for (int s = 1; s < STAGES; s++) begin
            sync_d.chain[s] = sync_q.chain[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= {STAGES{IDLE_LV}};
        else        sync_q <= sync_d;
    end

    assign synced = sync_q.chain[STAGES-1];

endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_lv,
    input  logic               sclk_lv,
    input  logic               din_lv,
    output logic               frame_ok,
    output logic [FRAME_W-1:0] frame_word
);
    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

    typedef struct packed {
        logic [FRAME_W-1:0] word;
        logic [CNT_W-1:0]   cnt;
        logic               cs_prev;
        logic               sclk_prev;
        logic               ok;
    } shf_t;

    shf_t shf_d, shf_q;
    logic cs_rise, sclk_rise;

    assign cs_rise   = cs_lv & ~shf_q.cs_prev;
    assign sclk_rise = sclk_lv & ~shf_q.sclk_prev;

    always_comb begin
        shf_d           = shf_q;
        shf_d.cs_prev   = cs_lv;
        shf_d.sclk_prev = sclk_lv;
        shf_d.ok        = 1'b0;
        if (cs_rise) begin
            shf_d.ok = (shf_q.cnt == FULL);
        end else if (cs_lv) begin
            shf_d.cnt = '0;
        end else if (sclk_rise) begin
            shf_d.word = {shf_q.word[FRAME_W-2:0], din_lv};
            if (shf_q.cnt <= FULL) shf_d.cnt = shf_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shf_q           <= '0;
            shf_q.cs_prev   <= 1'b1;
        end else begin
            shf_q <= shf_d;
        end
    end

    assign frame_ok   = shf_q.ok;
    assign frame_word = shf_q.word;

    // R7: the counter saturates one past a full frame
    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        shf_q.cnt <= FULL + 1'b1);

    // R5: a frame is accepted only right after chip select rose
    assert_ok_after_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        shf_q.ok |-> $past(cs_lv) && !$past(shf_q.cs_prev));

endmodule

// File: rtl/cmd_exec.sv
module cmd_exec
    import serial_dac_pkg::*;
#(
    parameter int DATA_W = DAC_BITS,
    parameter int CMD_W  = OP_BITS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_ok,
    input  logic [CMD_W+DATA_W-1:0] frame_word,
    output logic [DATA_W-1:0]       dac_code,
    output logic                    sleeping
);
    typedef struct packed {
        logic [DATA_W-1:0] stage;
        logic [DATA_W-1:0] live;
        logic              sleep;
    } regs_t;

    regs_t rg_d, rg_q;
    op_e               op;
    logic [DATA_W-1:0] payload;

    assign op      = op_e'(frame_word[CMD_W+DATA_W-1 -: CMD_W]);
    assign payload = frame_word[DATA_W-1:0];

    always_comb begin
        rg_d = rg_q;
        if (frame_ok) begin
            unique case (op)
                OP_STAGE:  rg_d.stage = payload;
                OP_COMMIT: begin
                    rg_d.live  = rg_q.stage;
                    rg_d.sleep = 1'b0;
                end
                OP_DIRECT: begin
                    rg_d.stage = payload;
                    rg_d.live  = payload;
                    rg_d.sleep = 1'b0;
                end
                OP_WAKE:   rg_d.sleep = 1'b0;
                OP_SLEEP:  rg_d.sleep = 1'b1;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign dac_code = rg_q.live;
    assign sleeping = rg_q.sleep;

    // R5: the converter code moves only after an accepted frame
    assert_dac_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_ok |=> $stable(rg_q.live));

    // R8: shutdown is entered only on an accepted frame
    assert_sleep_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rg_q.sleep) |-> $past(frame_ok));

    // R10: shutdown is left only on an accepted frame
    assert_sleep_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rg_q.sleep) |-> $past(frame_ok));

endmodule

// File: rtl/serial_dac_frontend.sv
module serial_dac_frontend
    import serial_dac_pkg::*;
#(
    parameter int DATA_W      = DAC_BITS,
    parameter int CMD_W       = OP_BITS,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    output logic [DATA_W-1:0] dac_code,
    output logic              pwr_down,
    output logic              out_hiz
);
    localparam int FRAME_W = CMD_W + DATA_W;

    logic [2:0]         lines;
    logic               frame_ok;
    logic [FRAME_W-1:0] frame_word;
    logic               sleeping;

    line_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .IDLE_LV(3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_in({cs_n, sclk, din}),
        .synced(lines)
    );

    frame_shifter #(
        .FRAME_W(FRAME_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_lv     (lines[2]),
        .sclk_lv   (lines[1]),
        .din_lv    (lines[0]),
        .frame_ok  (frame_ok),
        .frame_word(frame_word)
    );

    cmd_exec #(
        .DATA_W(DATA_W),
        .CMD_W (CMD_W)
    ) u_exec (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_ok  (frame_ok),
        .frame_word(frame_word),
        .dac_code  (dac_code),
        .sleeping  (sleeping)
    );

    assign pwr_down = sleeping;
    assign out_hiz  = sleeping;

endmodule

// File: tb/serial_dac_frontend_test.sv
module serial_dac_frontend_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic [12:0] dac_code;
    logic        pwr_down;
    logic        out_hiz;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    serial_dac_frontend uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .sclk    (sclk),
        .din     (din),
        .dac_code(dac_code),
        .pwr_down(pwr_down),
        .out_hiz (out_hiz)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [12:0] got, input logic [12:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic pulse_bit(input logic b);
        din = b;
        wait_clk(4);
        sclk = 1'b1;
        wait_clk(4);
        sclk = 1'b0;
    endtask

    task automatic send(input logic [2:0] op, input logic [12:0] val, input int nbits);
        logic [15:0] w;
        w = {op, val};
        cs_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < nbits; i++) pulse_bit(i < 16 ? w[15-i] : 1'b1);
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(12);
    endtask

    task automatic chk_state(input string tag, input logic [12:0] code, input logic sd);
        chk(tag, dac_code, code);
        chk(tag, {12'd0, pwr_down}, {12'd0, sd});
        chk(tag, {12'd0, out_hiz}, {12'd0, sd});
    endtask

    task automatic t_reset;
        chk_state("R1 reset", 13'h0000, 1'b0);
    endtask

    task automatic t_direct;
        send(3'b011, 13'h0A5C, 16);
        chk_state("R2 direct load", 13'h0A5C, 1'b0);
    endtask

    task automatic t_stage_commit;
        send(3'b001, 13'h1234, 16);
        chk("R3 stage keeps dac", dac_code, 13'h0A5C);
        send(3'b010, 13'h0000, 16);
        chk("R3 commit", dac_code, 13'h1234);
    endtask

    task automatic t_cs_high;
        for (int i = 0; i < 20; i++) pulse_bit(i[0]);
        wait_clk(12);
        chk("R4 idle clocks ignored", dac_code, 13'h1234);
        send(3'b011, 13'h0111, 16);
        chk("R4 port works after idle clocks", dac_code, 13'h0111);
    endtask

    task automatic t_release;
        logic [15:0] w;
        w = {3'b011, 13'h1FFF};
        cs_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < 16; i++) pulse_bit(w[15-i]);
        wait_clk(20);
        chk("R5 no update before release", dac_code, 13'h0111);
        cs_n = 1'b1;
        wait_clk(10);
        chk("R5 update after release", dac_code, 13'h1FFF);
        wait_clk(4);
    endtask

    task automatic t_split;
        logic [15:0] w;
        w = {3'b011, 13'h0F0F};
        cs_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < 8; i++) pulse_bit(w[15-i]);
        wait_clk(40);
        for (int i = 8; i < 16; i++) pulse_bit(w[15-i]);
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(12);
        chk("R6 split bursts", dac_code, 13'h0F0F);
    endtask

    task automatic t_bad_count;
        send(3'b011, 13'h0001, 15);
        chk("R7 short frame dropped", dac_code, 13'h0F0F);
        send(3'b011, 13'h0002, 17);
        chk("R7 long frame dropped", dac_code, 13'h0F0F);
        send(3'b010, 13'h0000, 16);
        chk("R7 input untouched", dac_code, 13'h0F0F);
    endtask

    task automatic t_reserved;
        send(3'b000, 13'h0AAA, 16);
        chk_state("R12 op 000", 13'h0F0F, 1'b0);
        send(3'b100, 13'h0AAA, 16);
        chk_state("R12 op 100", 13'h0F0F, 1'b0);
        send(3'b110, 13'h0AAA, 16);
        chk_state("R12 op 110", 13'h0F0F, 1'b0);
        send(3'b010, 13'h0000, 16);
        chk("R12 input untouched", dac_code, 13'h0F0F);
    endtask

    task automatic t_shutdown;
        send(3'b111, 13'h1555, 16);
        chk_state("R8 enter shutdown", 13'h0F0F, 1'b1);
        send(3'b001, 13'h0321, 16);
        chk_state("R9 stage while asleep", 13'h0F0F, 1'b1);
        send(3'b101, 13'h0000, 16);
        chk_state("R10 recall", 13'h0F0F, 1'b0);
        send(3'b111, 13'h0000, 16);
        chk_state("R8 enter again", 13'h0F0F, 1'b1);
        send(3'b010, 13'h0000, 16);
        chk_state("R11 commit wakes", 13'h0321, 1'b0);
        send(3'b111, 13'h0000, 16);
        send(3'b011, 13'h0456, 16);
        chk_state("R11 direct wakes", 13'h0456, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_direct();
        t_stage_commit();
        t_cs_high();
        t_release();
        t_split();
        t_bad_count();
        t_reserved();
        t_shutdown();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule